// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

The aggregator gathers up to 32 level-sensitive interrupt lines from on-chip peripherals. Each rising level on an implemented line is latched into a request register and a pending register. If the line is enabled in the mask register, the block signals the interrupt by issuing one posted 32-bit write on a bus-master port.

Both the address and the payload of that write come from a single delivery-address register. The address is the register value with its five low bits forced to zero. The payload is those five low bits alone. Software can suppress all deliveries by setting an error flag in the control register.

Software reaches the six 32-bit registers through a word-wide slave port. Bit 31 of the data bus is the most significant bit. Read data and the error response appear one clock after the strobe. The master port carries a single outstanding write with a valid/ready handshake. Interrupts that arrive while a write is in flight merge into one follow-up write, which is issued after the current one completes.

Top module: `msi_irq_agg`

## Requirements
- R1: A line whose implemented bit is set sets its bit in the request and pending registers at the clock edge where the line is first sampled high. A line held high does not set the bit again. Lines outside the implemented set (default bits 0 to 15) never set any bit.
- R2: A read of the pending register (offset 0x08) returns the value held before the read, then clears the register. A rise in the same cycle as the read survives the clear.
- R3: Any write to the pending register clears it, whatever data is written.
- R4: A write to the request register (offset 0x00) clears exactly the bits written as 1.
- R5: A write to the mask register (offset 0x04) with any bit set outside the implemented set is rejected, and the mask keeps its old value. The exception is 0xFFFFFFFF, which is accepted. Accepted values read back unchanged.
- R6: A masked-in rise at clock edge k raises m_valid at edge k+1. The write's address is the delivery-address register (offset 0x10) with bits 4:0 cleared. Its data is bits 4:0 of that register, zero-extended.
- R7: While m_valid is high and m_ready is low, m_valid, m_addr and m_data hold steady. Only one write is outstanding. Any number of masked-in rises during a write produce exactly one further write, whose m_valid rises on the edge after the completing handshake.
- R8: While control bit 0 (the bus-error flag, offset 0x0C) is set, no write is launched. A masked-in rise that arrives while the flag is set is discarded and causes no write after the flag clears.
- R9: A read of the control register returns the bus-error flag in bit 0, and every other bit reads zero.
- R10: After reset the delivery-address register holds 0xFFFB0003. The request, mask, pending and control registers hold zero, and m_valid is low.
- R11: The version register (offset 0x14) always reads zero, and writes to it have no effect.
- R12: Any read or write to an offset above 0x14, or to an offset that is not a multiple of 4, gets reg_err one cycle later. Such a write changes no register. Valid accesses get reg_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level interrupt inputs, synchronous to clk |
| reg_addr | input | AW | Register byte offset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| reg_err | output | 1 | Error response, the cycle after the strobe |
| m_valid | output | 1 | Delivery write valid |
| m_ready | input | 1 | Delivery write accepted |
| m_addr | output | 32 | Delivery write address |
| m_data | output | 32 | Delivery write payload |

## Verification
The bench reads the pending register in the same cycle that a new line rises. A design that applied the clear after the set would lose that interrupt. It raises further lines while a delivery is stalled on m_ready. A design that dropped them, or launched one write per line, would show no follow-up write or too many. It offers mask values with a single stray high bit, and the all-ones value. A design that took the stray value, or refused all-ones, would read back the wrong mask. It also raises a masked-in line under the bus-error flag and then clears the flag. A design that only deferred the delivery would emit a late write.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

  localparam int WORD_W = 32;

  // Register slots, one per 32-bit word, in offset order.
  typedef enum logic [2:0] {
    SLOT_REQ   = 3'd0,
    SLOT_MASK  = 3'd1,
    SLOT_PEND  = 3'd2,
    SLOT_CTRL  = 3'd3,
    SLOT_DADDR = 3'd4,
    SLOT_VER   = 3'd5
  } slot_e;

  localparam int NUM_SLOTS    = 6;
  localparam int ERR_FLAG_BIT = 0;
  localparam int ALIGN_LSBS   = 5;

  // A mask value is taken when it stays inside the implemented set,
  // or when it is the all-ones value.
  function automatic logic mask_accept(input logic [WORD_W-1:0] v,
                                       input logic [WORD_W-1:0] impl);
    return ((v & ~impl) == '0) || (v == {WORD_W{1'b1}});
  endfunction

endpackage

// File: rtl/msi_edge_det.sv
module msi_edge_det #(
  parameter int          NUM_LINES = 32,
  parameter logic [31:0] IMPL_BITS = 32'h0000_FFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] lines,
  output logic [31:0]          rise
);

  genvar i;
  generate
    for (i = 0; i < 32; i++) begin : g_bit
      if (i < NUM_LINES && IMPL_BITS[i]) begin : g_live
        logic prev_q;
        always_ff @(posedge clk) begin
          if (rst) prev_q <= 1'b0;
          else     prev_q <= lines[i];
        end
        assign rise[i] = lines[i] & ~prev_q;
      end else begin : g_dead
        assign rise[i] = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/msi_regbank.sv
module msi_regbank
  import msi_agg_pkg::*;
#(
  parameter int          AW        = 8,
  parameter logic [31:0] IMPL_BITS = 32'h0000_FFFF,
  parameter logic [31:0] DADDR_RST = 32'hFFFB_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              err,
  input  logic [WORD_W-1:0] rise,
  output logic [WORD_W-1:0] mask_o,
  output logic [WORD_W-1:0] daddr_o,
  output logic              bus_err_o
);

  localparam int IDXW = AW - 2;

  logic [IDXW-1:0]   idx;
  logic              hit;
  slot_e             sel;
  logic [WORD_W-1:0] req_q, mask_q, pend_q, daddr_q, rd_mux;
  logic              flag_q;
  logic              wr_req, wr_mask, wr_pend, wr_ctrl, wr_daddr, rd_pend;

  assign idx = addr[AW-1:2];
  assign hit = (addr[1:0] == 2'b00) && (idx < IDXW'(NUM_SLOTS));
  assign sel = slot_e'(idx[2:0]);

  assign wr_req   = wr && hit && (sel == SLOT_REQ);
  assign wr_mask  = wr && hit && (sel == SLOT_MASK);
  assign wr_pend  = wr && hit && (sel == SLOT_PEND);
  assign wr_ctrl  = wr && hit && (sel == SLOT_CTRL);
  assign wr_daddr = wr && hit && (sel == SLOT_DADDR);
  assign rd_pend  = rd && hit && (sel == SLOT_PEND);

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SLOT_REQ:   rd_mux = req_q;
      SLOT_MASK:  rd_mux = mask_q;
      SLOT_PEND:  rd_mux = pend_q;
      SLOT_CTRL:  rd_mux[ERR_FLAG_BIT] = flag_q;
      SLOT_DADDR: rd_mux = daddr_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      flag_q  <= 1'b0;
      daddr_q <= DADDR_RST;
      rdata   <= '0;
      err     <= 1'b0;
    end else begin
      req_q  <= (req_q & ~(wr_req ? wdata : '0)) | rise;
      pend_q <= ((rd_pend || wr_pend) ? '0 : pend_q) | rise;
      if (wr_mask && mask_accept(wdata, IMPL_BITS)) mask_q <= wdata;
      if (wr_ctrl)  flag_q  <= wdata[ERR_FLAG_BIT];
      if (wr_daddr) daddr_q <= wdata;
      err <= (rd || wr) && !hit;
      if (rd) rdata <= hit ? rd_mux : '0;
    end
  end

  assign mask_o    = mask_q;
  assign daddr_o   = daddr_q;
  assign bus_err_o = flag_q;

  assert_pend_clear_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rd_pend || wr_pend) |-> pend_q == $past(rise));

  assert_mask_reject_R5: assert property (@(posedge clk) disable iff (rst)
    $past(wr_mask && !mask_accept(wdata, IMPL_BITS)) |-> mask_q == $past(mask_q));

  assert_ctrl_read_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rd && hit && sel == SLOT_CTRL) |-> rdata[WORD_W-1:1] == '0);

  assert_version_zero_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rd && hit && sel == SLOT_VER) |-> rdata == '0);

  assert_err_resp_R12: assert property (@(posedge clk) disable iff (rst)
    $past((rd || wr) && !hit) |-> err);

endmodule

// File: rtl/msi_deliver.sv
module msi_deliver
  import msi_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rise,
  input  logic [WORD_W-1:0] mask,
  input  logic [WORD_W-1:0] daddr,
  input  logic              bus_err,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_addr,
  output logic [WORD_W-1:0] m_data
);

  logic owed_q;
  logic want, launch;

  assign want   = |(rise & mask);
  assign launch = !m_valid && owed_q && !bus_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q  <= 1'b0;
      m_valid <= 1'b0;
      m_addr  <= '0;
      m_data  <= '0;
    end else begin
      owed_q <= (owed_q && !launch) || (want && !bus_err);
      if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end else if (launch) begin
        m_valid <= 1'b1;
        m_addr  <= {daddr[WORD_W-1:ALIGN_LSBS], {ALIGN_LSBS{1'b0}}};
        m_data  <= {{(WORD_W-ALIGN_LSBS){1'b0}}, daddr[ALIGN_LSBS-1:0]};
      end
    end
  end

  assert_addr_form_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> m_addr == {$past(daddr[WORD_W-1:ALIGN_LSBS]), {ALIGN_LSBS{1'b0}}});

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_data));

  assert_no_launch_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> !$past(bus_err));

endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg #(
  parameter int          NUM_LINES = 32,
  parameter logic [31:0] IMPL_BITS = 32'h0000_FFFF,
  parameter int          AW        = 8,
  parameter logic [31:0] DADDR_RST = 32'hFFFB_0003
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 reg_err,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [31:0]          m_addr,
  output logic [31:0]          m_data
);

  logic [31:0] rise, mask, daddr;
  logic        bus_err;

  msi_edge_det #(.NUM_LINES(NUM_LINES), .IMPL_BITS(IMPL_BITS)) u_edge (
    .clk(clk), .rst(rst), .lines(irq_lines), .rise(rise)
  );

  msi_regbank #(.AW(AW), .IMPL_BITS(IMPL_BITS), .DADDR_RST(DADDR_RST)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .rd(reg_rd), .wr(reg_wr),
    .wdata(reg_wdata), .rdata(reg_rdata), .err(reg_err), .rise(rise),
    .mask_o(mask), .daddr_o(daddr), .bus_err_o(bus_err)
  );

  msi_deliver u_dlv (
    .clk(clk), .rst(rst), .rise(rise), .mask(mask), .daddr(daddr),
    .bus_err(bus_err), .m_valid(m_valid), .m_ready(m_ready),
    .m_addr(m_addr), .m_data(m_data)
  );

endmodule

// File: tb/msi_irq_agg_tb.sv
module msi_irq_agg_tb;

  localparam logic [7:0] A_REQ = 8'h00, A_MASK = 8'h04, A_PEND = 8'h08,
                         A_CTRL = 8'h0C, A_DADDR = 8'h10, A_VER = 8'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_lines = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0, m_ready = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, m_addr, m_data;
  logic        reg_err, m_valid;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  msi_irq_agg u_dut (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .m_valid(m_valid),
    .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data)
  );

  task automatic chk(input string rq, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h", rq, what, got, exp);
    end
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata; e = reg_err;
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] v, output logic e);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    e = reg_err;
  endtask

  task automatic set_line(input int i, input logic v);
    @(negedge clk);
    irq_lines[i] = v;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk("R10", "m_valid", {31'b0, m_valid}, 32'h0);
    reg_read(A_REQ, d, e);   chk("R10", "request", d, 32'h0);
    reg_read(A_MASK, d, e);  chk("R10", "mask", d, 32'h0);
    reg_read(A_PEND, d, e);  chk("R10", "pending", d, 32'h0);
    reg_read(A_CTRL, d, e);  chk("R10", "control", d, 32'h0);
    reg_read(A_DADDR, d, e); chk("R10", "daddr", d, 32'hFFFB_0003);
    reg_read(A_VER, d, e);   chk("R11", "version", d, 32'h0);
  endtask

  task automatic t_rise_regs();
    logic [31:0] d; logic e;
    set_line(3, 1'b1);
    reg_read(A_REQ, d, e);  chk("R1", "request after rise", d, 32'h8);
    reg_read(A_PEND, d, e); chk("R2", "pending first read", d, 32'h8);
    reg_read(A_PEND, d, e); chk("R2", "pending cleared, no retrigger R1", d, 32'h0);
    set_line(20, 1'b1);
    reg_read(A_REQ, d, e);  chk("R1", "unimplemented line ignored", d, 32'h8);
    reg_write(A_REQ, 32'h0000_0008, e);
    reg_read(A_REQ, d, e);  chk("R4", "request bit cleared by W1C", d, 32'h0);
    set_line(5, 1'b1);
    reg_write(A_PEND, 32'h0000_1234, e);
    reg_read(A_PEND, d, e); chk("R3", "pending cleared by write", d, 32'h0);
    // read and rise in the same cycle
    @(negedge clk);
    reg_addr = A_PEND; reg_rd = 1'b1; irq_lines[6] = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R2", "pending read value before same-cycle rise", reg_rdata, 32'h0);
    reg_read(A_PEND, d, e); chk("R2", "same-cycle rise survives clear", d, 32'h40);
    chk("R1", "masked-off lines give no write", {31'b0, m_valid}, 32'h0);
    @(negedge clk);
    irq_lines = '0;
    reg_write(A_REQ, 32'hFFFF_FFFF, e);
  endtask

  task automatic t_mask();
    logic [31:0] d; logic e;
    reg_write(A_MASK, 32'h0001_0000, e);
    reg_read(A_MASK, d, e); chk("R5", "stray bit 16 rejected", d, 32'h0);
    reg_write(A_MASK, 32'h0000_A5A5, e);
    reg_read(A_MASK, d, e); chk("R5", "in-range mask taken", d, 32'h0000_A5A5);
    reg_write(A_MASK, 32'h8000_0000, e);
    reg_read(A_MASK, d, e); chk("R5", "stray bit 31 rejected", d, 32'h0000_A5A5);
    reg_write(A_MASK, 32'hFFFF_FFFF, e);
    reg_read(A_MASK, d, e); chk("R5", "all-ones taken", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_deliver();
    logic e;
    reg_write(A_MASK, 32'h0000_0016, e);
    reg_write(A_DADDR, 32'h1234_5677, e);
    set_line(1, 1'b1);
    @(negedge clk);
    chk("R6", "m_valid not yet", {31'b0, m_valid}, 32'h0);
    @(negedge clk);
    chk("R6", "m_valid raised", {31'b0, m_valid}, 32'h1);
    chk("R6", "m_addr", m_addr, 32'h1234_5660);
    chk("R6", "m_data", m_data, 32'h0000_0017);
    irq_lines[2] = 1'b1; irq_lines[4] = 1'b1;
    reg_wdata = 32'hDEAD_BEE0;
    for (int k = 0; k < 3; k++) @(negedge clk);
    chk("R7", "m_valid held", {31'b0, m_valid}, 32'h1);
    chk("R7", "m_addr held", m_addr, 32'h1234_5660);
    chk("R7", "m_data held", m_data, 32'h0000_0017);
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    chk("R7", "m_valid dropped after handshake", {31'b0, m_valid}, 32'h0);
    @(negedge clk);
    chk("R7", "single follow-up write", {31'b0, m_valid}, 32'h1);
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (m_valid) seen++;
      end
      chk("R7", "no extra writes after merge", seen, 0);
    end
    @(negedge clk);
    irq_lines = '0;
  endtask

  task automatic t_buserr();
    logic [31:0] d; logic e;
    int seen = 0;
    reg_write(A_CTRL, 32'hFFFF_FFFF, e);
    reg_read(A_CTRL, d, e); chk("R9", "control reads only flag", d, 32'h1);
    set_line(2, 1'b1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (m_valid) seen++;
    end
    chk("R8", "no write while flag set", seen, 0);
    reg_write(A_CTRL, 32'h0, e);
    reg_read(A_CTRL, d, e); chk("R9", "control cleared", d, 32'h0);
    seen = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (m_valid) seen++;
    end
    chk("R8", "discarded rise gives no late write", seen, 0);
    set_line(2, 1'b0);
  endtask

  task automatic t_err();
    logic [31:0] d; logic e;
    reg_read(8'h18, d, e);  chk("R12", "read past range", {31'b0, e}, 32'h1);
    reg_read(8'h06, d, e);  chk("R12", "unaligned read", {31'b0, e}, 32'h1);
    reg_read(A_MASK, d, e); chk("R12", "valid read no error", {31'b0, e}, 32'h0);
    reg_write(8'h11, 32'h0, e); chk("R12", "unaligned write", {31'b0, e}, 32'h1);
    reg_read(A_DADDR, d, e); chk("R12", "unaligned write changed nothing", d, 32'h1234_5677);
    reg_write(A_VER, 32'hDEAD_BEEF, e);
    reg_read(A_VER, d, e);   chk("R11", "version after write", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rise_regs();
    t_mask();
    t_deliver();
    t_buserr();
    t_err();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL ALL watchdog got=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule